// File: doc/BRIEF.md
# Self-Checking Memory Traffic Generator

This block drives the user-side request port of a memory controller with a suite of write-then-read-back tests that repeats without end. It needs no software setup. For each request it issues a row, a bank and a column, a burst size, write data and byte enables. It waits on the controller's ready signal and compares every returned read word against a regenerated expected value. It is meant for bring-up and soak testing: point it at a controller, enable the tests wanted, and watch the sticky fail flag and the pass counter.

There are three tests, and each has its own enable input. The sweep test writes a pseudo-random word to every address of a parameterised row/bank/column space, then reseeds its generator and reads the whole space back. The short-burst test issues single-word writes and reads, which are smaller than the full local burst. The lane test first clears a range of words. It then rewrites each word with exactly one byte lane enabled and reads the range back. Expected read data is never stored: the data generator is reset to its seed and stepped once per returned word, because the controller returns reads in request order.

Top module: `mem_traffic_gen`

## Requirements
- R1: The tests run in the fixed order sweep, short-burst, lane. After the lane test slot the block goes back to the sweep test and repeats forever.
- R2: The sweep test writes, then reads, MAX_ROW*MAX_BANK*MAX_COL words. Addresses start at zero, the column advances fastest, then the bank, then the row.
- R3: Write data comes from a 32-bit Fibonacci LFSR with seed 32'h1D87_2B41. Each step computes next = {s[30:0], s[31]^s[21]^s[1]^s[0]}. Data bit i is state bit i mod 32, and the first accepted write of a pass carries the seed. The generator is reseeded before each read-back, so the k-th returned word is compared with the k-th value.
- R4: When an enable input is low, that test's slot issues no request. With every enable low, no request is issued at all and loops still complete.
- R5: The short-burst test issues size_o = 1 writes and reads to columns 0..PART_WORDS-1 of row 0 and bank 0. The other tests issue size_o = LOCAL_BURST. The short-burst test runs only when LOCAL_BURST equals 2; otherwise its slot is always skipped.
- R6: The lane test first writes zero with be_o all ones to columns 0..MASK_WORDS-1 of row 0 and bank 0. It then writes LFSR data to the same columns with be_o = 1 << (k mod BE_W) for the k-th word. Its expected read data is the LFSR byte in that lane and zero in every other lane.
- R7: A write or read request, with its address, data and enables, holds steady until ready_i is high at a clock edge. wr_o and rd_o are never high together.
- R8: A mismatch on a cycle with rdata_valid_i high sets fail_o, which stays set until reset. The mismatch also sets test_err_o bit 0, 1 or 2 for the sweep, short-burst or lane test. fail_addr_o latches {row,bank,col} of the first failing word.
- R9: pass_cnt_o increments by one after each full loop in which no mismatch occurred, and holds otherwise.
- R10: During reset no request is issued, and fail_o, test_err_o and pass_cnt_o are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| seq_en_i | input | 1 | Enable for the sweep test |
| part_en_i | input | 1 | Enable for the short-burst test |
| mask_en_i | input | 1 | Enable for the lane test |
| ready_i | input | 1 | Controller accepts the current request |
| rdata_i | input | DATA_W | Read data return |
| rdata_valid_i | input | 1 | Read data return is valid |
| wr_o | output | 1 | Write request |
| rd_o | output | 1 | Read request |
| row_o | output | ROW_W | Request row |
| bank_o | output | BANK_W | Request bank |
| col_o | output | COL_W | Request column |
| size_o | output | SIZE_W | Request burst size |
| wdata_o | output | DATA_W | Write data |
| be_o | output | DATA_W/8 | Byte enables |
| fail_o | output | 1 | Sticky mismatch flag |
| fail_addr_o | output | ROW_W+BANK_W+COL_W | First failing {row,bank,col} |
| test_err_o | output | 3 | Sticky per-test mismatch flags |
| pass_cnt_o | output | CNT_W | Count of error-free loops |

## Verification
The block is exercised under several patterns. Each test is run alone, and all three run together. All tests are disabled in one run. One run applies periodic backpressure. One run corrupts a single returned word. The solo runs pin down the address order, the data sequence and the size of each test. The combined run checks that the test slots follow each other in the right order and that the loop wraps back to the sweep test. Backpressure shows whether requests hold steady and whether the data sequence survives stalls. The corruption run checks the stickiness of the fail flag, the latched address and the per-test flag. It also checks that the pass counter holds back only for the erroneous loop. A second instance built with a local burst of four shows that the short-burst test is skipped at that size.

// File: rtl/mtg_pkg.sv
`timescale 1ns/1ps
package mtg_pkg;
  localparam int LFSR_W = 32;

  typedef enum logic [1:0] {
    T_SEQ  = 2'd0,
    T_PART = 2'd1,
    T_MASK = 2'd2
  } test_e;

  typedef enum logic [2:0] {
    P_SEL,
    P_CLR,
    P_WR,
    P_RD,
    P_WAIT,
    P_END
  } phase_e;
endpackage

// File: rtl/mtg_lfsr.sv
`timescale 1ns/1ps
module mtg_lfsr #(
  parameter int          DATA_W = 32,
  parameter logic [31:0] SEED   = 32'h1D87_2B41
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              seed_ld_i,
  input  logic              step_i,
  output logic [DATA_W-1:0] word_o
);
  import mtg_pkg::*;

  logic [LFSR_W-1:0] state_q;
  logic              fb;

  assign fb = state_q[31] ^ state_q[21] ^ state_q[1] ^ state_q[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        state_q <= SEED;
    else if (seed_ld_i) state_q <= SEED;
    else if (step_i)    state_q <= {state_q[LFSR_W-2:0], fb};
  end

  // replicate state across the data width
  for (genvar g = 0; g < DATA_W; g++) begin : g_fill
    assign word_o[g] = state_q[g % LFSR_W];
  end
endmodule

// File: rtl/mtg_addr_gen.sv
`timescale 1ns/1ps
module mtg_addr_gen #(
  parameter int ROW_W  = 3,
  parameter int BANK_W = 2,
  parameter int COL_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              step_i,
  input  logic [ROW_W:0]    row_lim_i,
  input  logic [BANK_W:0]   bank_lim_i,
  input  logic [COL_W:0]    col_lim_i,
  output logic [ROW_W-1:0]  row_o,
  output logic [BANK_W-1:0] bank_o,
  output logic [COL_W-1:0]  col_o
);
  localparam logic [ROW_W:0]  ROW_ONE  = 1;
  localparam logic [BANK_W:0] BANK_ONE = 1;
  localparam logic [COL_W:0]  COL_ONE  = 1;

  logic [ROW_W-1:0]  row_q;
  logic [BANK_W-1:0] bank_q;
  logic [COL_W-1:0]  col_q;
  logic row_last, bank_last, col_last;

  assign row_last  = ({1'b0, row_q}  == row_lim_i  - ROW_ONE);
  assign bank_last = ({1'b0, bank_q} == bank_lim_i - BANK_ONE);
  assign col_last  = ({1'b0, col_q}  == col_lim_i  - COL_ONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_q  <= '0;
      bank_q <= '0;
      col_q  <= '0;
    end else if (clr_i) begin
      row_q  <= '0;
      bank_q <= '0;
      col_q  <= '0;
    end else if (step_i) begin
      if (!col_last) begin
        col_q <= col_q + 1'b1;
      end else begin
        col_q <= '0;
        if (!bank_last) begin
          bank_q <= bank_q + 1'b1;
        end else begin
          bank_q <= '0;
          row_q  <= row_last ? '0 : row_q + 1'b1;
        end
      end
    end
  end

  assign row_o  = row_q;
  assign bank_o = bank_q;
  assign col_o  = col_q;
endmodule

// File: rtl/mtg_rd_check.sv
`timescale 1ns/1ps
module mtg_rd_check #(
  parameter int DATA_W = 32,
  parameter int BE_W   = 4,
  parameter int LANE_W = 2
) (
  input  logic              valid_i,
  input  logic              mask_mode_i,
  input  logic [LANE_W-1:0] lane_i,
  input  logic [DATA_W-1:0] word_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic              mismatch_o
);
  logic [DATA_W-1:0] expect_w;

  // in lane mode only the written lane keeps data, the rest were cleared
  for (genvar g = 0; g < BE_W; g++) begin : g_lane
    assign expect_w[8*g +: 8] = (!mask_mode_i || lane_i == LANE_W'(g)) ? word_i[8*g +: 8] : 8'h00;
  end

  assign mismatch_o = valid_i && (rdata_i != expect_w);
endmodule

// File: rtl/mem_traffic_gen.sv
`timescale 1ns/1ps
module mem_traffic_gen #(
  parameter int          ROW_W       = 3,
  parameter int          BANK_W      = 2,
  parameter int          COL_W       = 4,
  parameter int          MAX_ROW     = 2,
  parameter int          MAX_BANK    = 2,
  parameter int          MAX_COL     = 4,
  parameter int          DATA_W      = 32,
  parameter int          SIZE_W      = 3,
  parameter int          LOCAL_BURST = 2,
  parameter int          PART_WORDS  = 4,
  parameter int          MASK_WORDS  = 6,
  parameter int          CNT_W       = 16,
  parameter logic [31:0] SEED        = 32'h1D87_2B41
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            seq_en_i,
  input  logic                            part_en_i,
  input  logic                            mask_en_i,
  input  logic                            ready_i,
  input  logic [DATA_W-1:0]               rdata_i,
  input  logic                            rdata_valid_i,
  output logic                            wr_o,
  output logic                            rd_o,
  output logic [ROW_W-1:0]                row_o,
  output logic [BANK_W-1:0]               bank_o,
  output logic [COL_W-1:0]                col_o,
  output logic [SIZE_W-1:0]               size_o,
  output logic [DATA_W-1:0]               wdata_o,
  output logic [DATA_W/8-1:0]             be_o,
  output logic                            fail_o,
  output logic [ROW_W+BANK_W+COL_W-1:0]   fail_addr_o,
  output logic [2:0]                      test_err_o,
  output logic [CNT_W-1:0]                pass_cnt_o
);
  import mtg_pkg::*;

  localparam int  BE_W    = DATA_W / 8;
  localparam int  LANE_W  = (BE_W > 1) ? $clog2(BE_W) : 1;
  localparam int  ADDR_W  = ROW_W + BANK_W + COL_W;
  localparam int  N_SEQ   = MAX_ROW * MAX_BANK * MAX_COL;
  localparam int  N_PM    = (PART_WORDS > MASK_WORDS) ? PART_WORDS : MASK_WORDS;
  localparam int  N_MAX   = (N_SEQ > N_PM) ? N_SEQ : N_PM;
  localparam int  IDX_W   = $clog2(N_MAX + 1);
  localparam bit  PART_OK = (LOCAL_BURST == 2);
  localparam logic [IDX_W-1:0]  IDX_ONE = 1;
  localparam logic [SIZE_W-1:0] SZ_FULL = SIZE_W'(LOCAL_BURST);
  localparam logic [SIZE_W-1:0] SZ_PART = SIZE_W'(1);
  localparam logic [BE_W-1:0]   BE_ONE  = 1;

  test_e  test_q;
  phase_e phase_q;

  logic [IDX_W-1:0]  req_idx_q, ret_idx_q, n_words;
  logic              loop_err_q, fail_q;
  logic [ADDR_W-1:0] fail_addr_q;
  logic [2:0]        test_err_q;
  logic [CNT_W-1:0]  pass_cnt_q;

  logic [ROW_W:0]    row_lim;
  logic [BANK_W:0]   bank_lim;
  logic [COL_W:0]    col_lim;
  logic [2:0]        en_vec;

  logic              is_wr, is_rd, accept, last_req, last_ret, ret_valid, mismatch;
  logic              lfsr_ld, lfsr_step, sel_phase;
  logic [DATA_W-1:0] lfsr_word;
  logic [ROW_W-1:0]  ret_row;
  logic [BANK_W-1:0] ret_bank;
  logic [COL_W-1:0]  ret_col;

  assign en_vec = {mask_en_i, part_en_i && PART_OK, seq_en_i};

  always_comb begin
    unique case (test_q)
      T_SEQ: begin
        n_words  = IDX_W'(N_SEQ);
        row_lim  = (ROW_W+1)'(MAX_ROW);
        bank_lim = (BANK_W+1)'(MAX_BANK);
        col_lim  = (COL_W+1)'(MAX_COL);
      end
      T_PART: begin
        n_words  = IDX_W'(PART_WORDS);
        row_lim  = (ROW_W+1)'(1);
        bank_lim = (BANK_W+1)'(1);
        col_lim  = (COL_W+1)'(PART_WORDS);
      end
      default: begin
        n_words  = IDX_W'(MASK_WORDS);
        row_lim  = (ROW_W+1)'(1);
        bank_lim = (BANK_W+1)'(1);
        col_lim  = (COL_W+1)'(MASK_WORDS);
      end
    endcase
  end

  assign sel_phase = (phase_q == P_SEL);
  assign is_wr     = (phase_q == P_CLR) || (phase_q == P_WR);
  assign is_rd     = (phase_q == P_RD);
  assign accept    = (is_wr || is_rd) && ready_i;
  assign last_req  = (req_idx_q == n_words - IDX_ONE);
  assign last_ret  = (ret_idx_q == n_words - IDX_ONE);
  assign ret_valid = rdata_valid_i && ((phase_q == P_RD) || (phase_q == P_WAIT));

  // reseed before each write pass and before each read-back
  assign lfsr_ld   = sel_phase || (phase_q == P_CLR) ||
                     ((phase_q == P_WR) && accept && last_req);
  assign lfsr_step = ((phase_q == P_WR) && accept) || ret_valid;

  mtg_lfsr #(.DATA_W(DATA_W), .SEED(SEED)) u_lfsr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .seed_ld_i(lfsr_ld),
    .step_i   (lfsr_step),
    .word_o   (lfsr_word)
  );

  mtg_addr_gen #(.ROW_W(ROW_W), .BANK_W(BANK_W), .COL_W(COL_W)) u_req_addr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (sel_phase),
    .step_i    (accept),
    .row_lim_i (row_lim),
    .bank_lim_i(bank_lim),
    .col_lim_i (col_lim),
    .row_o     (row_o),
    .bank_o    (bank_o),
    .col_o     (col_o)
  );

  mtg_addr_gen #(.ROW_W(ROW_W), .BANK_W(BANK_W), .COL_W(COL_W)) u_ret_addr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (sel_phase),
    .step_i    (ret_valid),
    .row_lim_i (row_lim),
    .bank_lim_i(bank_lim),
    .col_lim_i (col_lim),
    .row_o     (ret_row),
    .bank_o    (ret_bank),
    .col_o     (ret_col)
  );

  mtg_rd_check #(.DATA_W(DATA_W), .BE_W(BE_W), .LANE_W(LANE_W)) u_rd_check (
    .valid_i    (ret_valid),
    .mask_mode_i(test_q == T_MASK),
    .lane_i     (ret_idx_q[LANE_W-1:0]),
    .word_i     (lfsr_word),
    .rdata_i    (rdata_i),
    .mismatch_o (mismatch)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      test_q    <= T_SEQ;
      phase_q   <= P_SEL;
      req_idx_q <= '0;
      ret_idx_q <= '0;
    end else begin
      if (sel_phase || (accept && last_req)) req_idx_q <= '0;
      else if (accept)                       req_idx_q <= req_idx_q + IDX_ONE;

      if (sel_phase || (ret_valid && last_ret)) ret_idx_q <= '0;
      else if (ret_valid)                       ret_idx_q <= ret_idx_q + IDX_ONE;

      unique case (phase_q)
        P_SEL: begin
          if (en_vec[test_q]) begin
            phase_q <= (test_q == T_MASK) ? P_CLR : P_WR;
          end else if (test_q == T_MASK) begin
            phase_q <= P_END;
          end else begin
            test_q <= test_e'(test_q + 2'd1);
          end
        end
        P_CLR: if (accept && last_req) phase_q <= P_WR;
        P_WR:  if (accept && last_req) phase_q <= P_RD;
        P_RD, P_WAIT: begin
          if (ret_valid && last_ret) begin
            if (test_q == T_MASK) begin
              phase_q <= P_END;
            end else begin
              test_q  <= test_e'(test_q + 2'd1);
              phase_q <= P_SEL;
            end
          end else if (phase_q == P_RD && accept && last_req) begin
            phase_q <= P_WAIT;
          end
        end
        default: begin
          test_q  <= T_SEQ;
          phase_q <= P_SEL;
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      loop_err_q  <= 1'b0;
      fail_q      <= 1'b0;
      fail_addr_q <= '0;
      test_err_q  <= '0;
      pass_cnt_q  <= '0;
    end else begin
      if (mismatch) begin
        loop_err_q         <= 1'b1;
        fail_q             <= 1'b1;
        test_err_q[test_q] <= 1'b1;
        if (!fail_q) fail_addr_q <= {ret_row, ret_bank, ret_col};
      end
      if (phase_q == P_END) begin
        loop_err_q <= 1'b0;
        if (!loop_err_q) pass_cnt_q <= pass_cnt_q + 1'b1;
      end
    end
  end

  assign wr_o        = is_wr;
  assign rd_o        = is_rd;
  assign size_o      = (test_q == T_PART) ? SZ_PART : SZ_FULL;
  assign wdata_o     = (phase_q == P_CLR) ? '0 : lfsr_word;
  assign be_o        = ((phase_q == P_WR) && (test_q == T_MASK)) ?
                       (BE_ONE << req_idx_q[LANE_W-1:0]) : '1;
  assign fail_o      = fail_q;
  assign fail_addr_o = fail_addr_q;
  assign test_err_o  = test_err_q;
  assign pass_cnt_o  = pass_cnt_q;
endmodule

// File: rtl/mtg_sva.sv
`timescale 1ns/1ps
module mtg_sva #(
  parameter int ADDR_W      = 9,
  parameter int DATA_W      = 32,
  parameter int BE_W        = 4,
  parameter int SIZE_W      = 3,
  parameter int CNT_W       = 16,
  parameter int LOCAL_BURST = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_i,
  input logic              rd_i,
  input logic              ready_i,
  input logic              rdata_valid_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [BE_W-1:0]   be_i,
  input logic [SIZE_W-1:0] size_i,
  input logic              fail_i,
  input logic [CNT_W-1:0]  pass_cnt_i
);
  // R7
  req_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) !(wr_i && rd_i));

  // R7
  wr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !ready_i) |=> (wr_i && $stable(addr_i) && $stable(wdata_i) && $stable(be_i)));

  // R7
  rd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !ready_i) |=> (rd_i && $stable(addr_i)));

  // R8
  fail_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) fail_i |=> fail_i);

  // R8
  fail_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fail_i) |-> $past(rdata_valid_i));

  // R9
  pass_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (pass_cnt_i == $past(pass_cnt_i) || pass_cnt_i == $past(pass_cnt_i) + CNT_W'(1)));

  // R6
  be_shape_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |-> ($onehot(be_i) || (&be_i)));

  // R5
  size_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i || rd_i) |-> (size_i != '0 && size_i <= SIZE_W'(LOCAL_BURST)));
endmodule

bind mem_traffic_gen mtg_sva #(
  .ADDR_W     (ROW_W + BANK_W + COL_W),
  .DATA_W     (DATA_W),
  .BE_W       (DATA_W / 8),
  .SIZE_W     (SIZE_W),
  .CNT_W      (CNT_W),
  .LOCAL_BURST(LOCAL_BURST)
) u_sva (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .wr_i         (wr_o),
  .rd_i         (rd_o),
  .ready_i      (ready_i),
  .rdata_valid_i(rdata_valid_i),
  .addr_i       ({row_o, bank_o, col_o}),
  .wdata_i      (wdata_o),
  .be_i         (be_o),
  .size_i       (size_o),
  .fail_i       (fail_o),
  .pass_cnt_i   (pass_cnt_o)
);

// File: tb/mem_traffic_gen_tb.sv
`timescale 1ns/1ps
module mem_traffic_gen_tb;
  localparam logic [31:0] SEED = 32'h1D87_2B41;
  localparam int ADDR_W = 9;
  localparam int N_SEQ  = 16;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        seq_en = 1'b0, part_en = 1'b0, mask_en = 1'b0;
  logic        ready = 1'b1, rvalid = 1'b0;
  logic [31:0] rdata = '0;

  logic        wr, rd, fail;
  logic [2:0]  row, sz, terr;
  logic [1:0]  bank;
  logic [3:0]  col, be;
  logic [31:0] wdata;
  logic [8:0]  faddr;
  logic [15:0] pcnt;

  logic        d4_wr, d4_rd, d4_fail;
  logic [2:0]  d4_row, d4_sz, d4_terr;
  logic [1:0]  d4_bank;
  logic [3:0]  d4_col, d4_be;
  logic [31:0] d4_wdata;
  logic [8:0]  d4_faddr;
  logic [15:0] d4_pcnt;

  mem_traffic_gen u_dut (
    .clk_i(clk), .rst_ni(rst_n), .seq_en_i(seq_en), .part_en_i(part_en), .mask_en_i(mask_en),
    .ready_i(ready), .rdata_i(rdata), .rdata_valid_i(rvalid),
    .wr_o(wr), .rd_o(rd), .row_o(row), .bank_o(bank), .col_o(col), .size_o(sz),
    .wdata_o(wdata), .be_o(be), .fail_o(fail), .fail_addr_o(faddr), .test_err_o(terr),
    .pass_cnt_o(pcnt));

  mem_traffic_gen #(.LOCAL_BURST(4)) u_dut4 (
    .clk_i(clk), .rst_ni(rst_n), .seq_en_i(1'b0), .part_en_i(1'b1), .mask_en_i(1'b0),
    .ready_i(1'b1), .rdata_i(32'h0), .rdata_valid_i(1'b0),
    .wr_o(d4_wr), .rd_o(d4_rd), .row_o(d4_row), .bank_o(d4_bank), .col_o(d4_col), .size_o(d4_sz),
    .wdata_o(d4_wdata), .be_o(d4_be), .fail_o(d4_fail), .fail_addr_o(d4_faddr),
    .test_err_o(d4_terr), .pass_cnt_o(d4_pcnt));

  int checks = 0, errors = 0;
  logic [31:0] mem [0:(1<<ADDR_W)-1];
  logic        p1_v;
  logic [31:0] p1_d;
  int          rd_seen, corrupt_at = -1, cyc, hold_viol, d4_reqs;
  bit          bp_en;
  bit          hold_pend, hold_wr;
  logic [8:0]  hold_a;
  logic [31:0] hold_d;
  logic [8:0]  wa_q[$], ra_q[$];
  logic [31:0] wd_q[$];
  logic [3:0]  wbe_q[$];
  logic [2:0]  wsz_q[$], rsz_q[$];

  initial for (int i = 0; i < (1<<ADDR_W); i++) mem[i] = '0;

  // behavioural memory, evaluated away from the active edge
  always @(negedge clk) begin
    if (!rst_n) begin
      p1_v = 1'b0; rvalid = 1'b0; rd_seen = 0; ready = 1'b1; cyc = 0; hold_pend = 1'b0;
    end else begin
      cyc++;
      ready = !bp_en || (cyc % 3 != 0);
      rvalid = p1_v; rdata = p1_d; p1_v = 1'b0;
      if (hold_pend) begin
        if ((hold_wr ? !wr : !rd) || {row, bank, col} != hold_a || (hold_wr && wdata != hold_d))
          hold_viol++;
      end
      hold_pend = (wr || rd) && !ready;
      hold_wr = wr; hold_a = {row, bank, col}; hold_d = wdata;
      if (wr && ready) begin
        for (int b = 0; b < 4; b++) if (be[b]) mem[{row, bank, col}][8*b +: 8] = wdata[8*b +: 8];
        wa_q.push_back({row, bank, col}); wd_q.push_back(wdata);
        wbe_q.push_back(be); wsz_q.push_back(sz);
      end
      if (rd && ready) begin
        p1_v = 1'b1;
        p1_d = mem[{row, bank, col}] ^ ((rd_seen == corrupt_at) ? 32'h1 : 32'h0);
        rd_seen++;
        ra_q.push_back({row, bank, col}); rsz_q.push_back(sz);
      end
      if (d4_wr || d4_rd) d4_reqs++;
    end
  end

  function automatic logic [31:0] nxt(logic [31:0] s);
    return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
  endfunction

  function automatic logic [8:0] seq_addr(int k);
    return {3'(k / 8), 2'((k / 4) % 2), 4'(k % 4)};
  endfunction

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic apply_reset(bit se, bit pe, bit me, bit bp, int corr);
    rst_n = 1'b0;
    seq_en = se; part_en = pe; mask_en = me; bp_en = bp; corrupt_at = corr;
    hold_viol = 0; d4_reqs = 0;
    wa_q.delete(); wd_q.delete(); wbe_q.delete(); wsz_q.delete(); ra_q.delete(); rsz_q.delete();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wait_pass(int target, int maxc);
    for (int i = 0; i < maxc && pcnt < 16'(target); i++) @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk(!wr && !rd, "R10 no request in reset", {wr, rd}, 0);
    chk(!fail && terr == 0, "R10 flags clear", {fail, terr}, 0);
    chk(pcnt == 0, "R10 pass count clear", pcnt, 0);
    chk(!d4_wr && !d4_rd && d4_pcnt == 0, "R10 second instance idle", {d4_wr, d4_rd, d4_pcnt}, 0);
  endtask

  task automatic t_seq();
    logic [31:0] s = SEED;
    bit ok_a = 1, ok_d = 1, ok_s = 1, ok_r = 1;
    apply_reset(1, 0, 0, 0, -1);
    wait_pass(2, 600);
    chk(pcnt >= 2 && !fail, "R9 sweep loops pass", pcnt, 2);
    chk(wa_q.size() >= 2*N_SEQ && ra_q.size() >= N_SEQ, "R2 request count", wa_q.size(), 2*N_SEQ);
    if (wa_q.size() >= 2*N_SEQ && ra_q.size() >= N_SEQ) begin
      for (int k = 0; k < N_SEQ; k++) begin
        if (wa_q[k] != seq_addr(k) || ra_q[k] != seq_addr(k)) ok_a = 0;
        if (wd_q[k] != s || wbe_q[k] != 4'hF) ok_d = 0;
        if (wsz_q[k] != 3'd2 || rsz_q[k] != 3'd2) ok_s = 0;
        s = nxt(s);
      end
      chk(ok_a, "R2 column-bank-row order", wa_q[5], seq_addr(5));
      chk(ok_d, "R3 lfsr write data", wd_q[1], nxt(SEED));
      chk(ok_s, "R5 full burst size", wsz_q[0], 2);
      ok_r = (wa_q[N_SEQ] == 9'h0) && (wsz_q[N_SEQ] == 3'd2) && (wd_q[N_SEQ] == SEED);
      chk(ok_r, "R4 disabled slots skipped", wa_q[N_SEQ], 0);
    end
  endtask

  task automatic t_backpressure();
    logic [31:0] s = SEED;
    bit ok = 1;
    apply_reset(1, 0, 0, 1, -1);
    wait_pass(2, 1500);
    chk(pcnt >= 2 && !fail, "R7 loops pass under backpressure", pcnt, 2);
    chk(hold_viol == 0, "R7 request held while not ready", hold_viol, 0);
    if (wd_q.size() >= N_SEQ)
      for (int k = 0; k < N_SEQ; k++) begin
        if (wd_q[k] != s || wa_q[k] != seq_addr(k)) ok = 0;
        s = nxt(s);
      end
    chk(ok && wd_q.size() >= N_SEQ, "R3 sequence survives stalls", wd_q.size(), N_SEQ);
  endtask

  task automatic t_part();
    logic [31:0] s = SEED;
    bit ok = 1;
    apply_reset(0, 1, 0, 0, -1);
    wait_pass(1, 400);
    chk(pcnt >= 1 && !fail, "R5 short test passes", pcnt, 1);
    if (wa_q.size() >= 4 && ra_q.size() >= 4)
      for (int k = 0; k < 4; k++) begin
        if (wa_q[k] != 9'(k) || ra_q[k] != 9'(k) || wsz_q[k] != 3'd1 || rsz_q[k] != 3'd1 || wd_q[k] != s) ok = 0;
        s = nxt(s);
      end
    else ok = 0;
    chk(ok, "R5 single-word requests", wsz_q.size() > 0 ? wsz_q[0] : 3'd7, 1);
  endtask

  task automatic t_mask();
    logic [31:0] s = SEED, lm;
    bit ok_c = 1, ok_w = 1, ok_m = 1;
    apply_reset(0, 0, 1, 0, -1);
    wait_pass(1, 400);
    chk(pcnt >= 1 && !fail, "R6 lane test passes", pcnt, 1);
    if (wa_q.size() >= 12) begin
      for (int k = 0; k < 6; k++) begin
        if (wa_q[k] != 9'(k) || wd_q[k] != 0 || wbe_q[k] != 4'hF) ok_c = 0;
        if (wa_q[6+k] != 9'(k) || wbe_q[6+k] != 4'(1 << (k % 4)) || wd_q[6+k] != s) ok_w = 0;
        lm = 32'hFF << (8 * (k % 4));
        if (mem[k] != (s & lm)) ok_m = 0;
        s = nxt(s);
      end
    end else begin
      ok_c = 0; ok_w = 0; ok_m = 0;
    end
    chk(ok_c, "R6 clear pass", wbe_q.size() > 0 ? wbe_q[0] : 4'h0, 4'hF);
    chk(ok_w, "R6 one lane per word", wbe_q.size() > 7 ? wbe_q[7] : 4'h0, 4'h2);
    chk(ok_m, "R6 memory holds lane data only", mem[5], nxt(nxt(nxt(nxt(nxt(SEED))))) & 32'h0000FF00);
  endtask

  task automatic t_all();
    apply_reset(1, 1, 1, 0, -1);
    wait_pass(2, 1200);
    chk(pcnt >= 2 && !fail, "R1 full suite loops", pcnt, 2);
    if (wa_q.size() >= 33) begin
      chk(wsz_q[15] == 3'd2 && wsz_q[16] == 3'd1 && wa_q[16] == 9'h0, "R1 short test follows sweep", wsz_q[16], 1);
      chk(wsz_q[20] == 3'd2 && wd_q[20] == 0 && wbe_q[20] == 4'hF, "R1 lane test follows short test", wd_q[20], 0);
      chk(wa_q[32] == 9'h0 && wd_q[32] == SEED && wsz_q[32] == 3'd2, "R1 wraps to sweep", wd_q[32], SEED);
    end else chk(0, "R1 write count", wa_q.size(), 33);
  endtask

  task automatic t_none();
    apply_reset(0, 0, 0, 0, -1);
    repeat (60) @(negedge clk);
    chk(wa_q.size() == 0 && ra_q.size() == 0, "R4 no requests when all disabled", wa_q.size() + ra_q.size(), 0);
    chk(pcnt > 0, "R4 empty loops complete", pcnt, 1);
    chk(d4_reqs == 0, "R5 short test skipped at burst four", d4_reqs, 0);
    chk(d4_pcnt > 0 && !d4_fail, "R5 burst-four loops complete", d4_pcnt, 1);
  endtask

  task automatic t_fail();
    apply_reset(1, 0, 0, 0, 5);
    repeat (55) @(negedge clk);
    chk(fail, "R8 fail set on mismatch", fail, 1);
    chk(faddr == 9'h011, "R8 first failing address", faddr, 9'h011);
    chk(terr == 3'b001, "R8 per-test flag", terr, 3'b001);
    chk(pcnt == 0, "R9 erroneous loop not counted", pcnt, 0);
    wait_pass(1, 300);
    chk(pcnt == 1, "R9 clean loop counted", pcnt, 1);
    chk(fail && faddr == 9'h011, "R8 fail sticky", {fail, faddr}, {1'b1, 9'h011});
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #1200000;
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    t_reset();
    t_seq();
    t_backpressure();
    t_part();
    t_mask();
    t_all();
    t_none();
    t_fail();
    finish_run();
  end
endmodule